// File: doc/BRIEF.md
# Dequantizing Column Inverse DCT Stage

This block performs the column half of a separable 8x8 inverse DCT. For each of eight columns, one after another, it accepts eight signed coefficients. It fetches the matching multipliers from an external quantization table, forms the dequantized products and passes them through a scaled 8-point butterfly network. The eight 32-bit results go into an 8x8 intermediate buffer, placed so that a following row stage reads each buffer row with consecutive addresses.

The multipliers in the table already carry a scale of 2^13, so the products enter the butterflies without any further scaling. When the seven AC coefficients of a column are all zero, the block skips the butterfly network. It fetches only the DC multiplier and writes the dequantized DC value to all eight outputs. The table read position still moves on by a full column.

The coefficient input and the buffer write output are valid/ready streams. A column moves when `col_valid` and `col_ready` are both high at a clock edge. `col_ready` is high only while the block waits for its next column, and the source must hold `col_coef` until the transfer. A buffer write completes when `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the block holds `wr_valid`, `wr_addr` and `wr_data` unchanged. `start` and `done` are plain single-cycle pulses.

Top module: `col_idct_pass1`

## Requirements
- R1: After reset, `col_ready`, `wr_valid`, `qt_rd_en` and `done` are all low.
- R2: A `start` pulse while idle begins a run of eight columns, numbered 0 to 7 in arrival order. `col_ready` is high in the cycle after `start` and drops in the cycle after each column is taken. A `start` pulse during a run is ignored.
- R3: Each coefficient (signed, 16 bits) is multiplied by its multiplier (unsigned, 16 bits). The product is kept as a 32-bit two's-complement value.
- R4: Table word 8*c+s holds the multiplier for coefficient row ORDER[s] of column c, where ORDER = (7,5,1,3,0,2,4,6). A column with any nonzero AC term reads words 8*c to 8*c+7 in ascending order on consecutive cycles. `qt_rdata` returns one cycle after `qt_rd_en`.
- R5: When coefficients 1 to 7 of a column are all zero, the column makes exactly one table read, at word 8*c+4. All eight of its outputs equal the dequantized DC product.
- R6: After either kind of column, the reads of the next column start at word 8*(c+1), so every column stays aligned with its own multipliers.
- R7: Let d0..d7 be the row products and mh(x,k) = floor(x*k/65536). Even part: E0=(d0+d4)+(d2+d6), E3=(d0+d4)-(d2+d6). With g=d2-d6, M=mh(g,27146)+g-(d2+d6). Then E1=(d0-d4)+M and E2=(d0-d4)-M. Odd part: S=(d1+d7)+(d3+d5). With h=(d1+d7)-(d3+d5), P=mh(h,27146)+h. With a=d5-d3, b=d1-d7 and T=mh(a+b,15137): W6=8*(mh(a,-21407)+T)-S, W5=P-W6, W4=8*(mh(b,-8867)+T)-W5. The outputs are y0=E0+S, y1=E1+W6, y2=E2+W5, y3=E3+W4, y4=E3-W4, y5=E2-W5, y6=E1-W6, y7=E0-S. All arithmetic wraps at 32 bits.
- R8: Output k of column c is written to buffer address 8*k+c. A column's eight writes come in the order k = 0 to 7.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged in the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the last write of column 7 is accepted. A `start` pulse in that same cycle begins a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an eight-column run |
| done | output | 1 | One-cycle pulse when the run is complete |
| col_valid | input | 1 | Coefficient column offered |
| col_ready | output | 1 | Block is waiting for a column |
| col_coef | input | 128 | Eight signed coefficients, row k in bits 16k+15:16k |
| qt_rd_en | output | 1 | Quantization table read strobe |
| qt_addr | output | 6 | Quantization table word address |
| qt_rdata | input | 16 | Table word, one cycle after the strobe |
| wr_valid | output | 1 | Buffer write offered |
| wr_ready | input | 1 | Buffer accepts the write |
| wr_addr | output | 6 | Buffer address, 8*row + column |
| wr_data | output | 32 | Result word |

## Verification
Two events can meet in one cycle: the `done` pulse that ends a run and the `start` pulse that begins the next. The bench raises `start` in the very cycle where it sees `done`. It then expects `col_ready` one cycle later and a complete, correctly addressed second run. A second overlap matters just as much: a `start` arriving in the middle of a run, while the block is busy fetching. The bench provokes this and expects it to leave the write count, the write addresses and the read sequence of that run unchanged. Throughout, random `wr_ready` stalls test that a held write keeps its address and data.

// File: rtl/colidct_pkg.sv
package colidct_pkg;
  localparam int NPT  = 8;
  localparam int IDXW = $clog2(NPT);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TAKE, ST_FETCH, ST_DRAIN, ST_CALC, ST_EMIT
  } seq_st_e;

  // slot in the quant table that carries the DC multiplier
  localparam logic [IDXW-1:0] DC_SLOT  = IDXW'(4);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NPT - 1);

  // fixed-point rotation constants, value/65536
  localparam logic signed [15:0] K_R2M1 = 16'sd27146;
  localparam logic signed [15:0] K_C2   = 16'sd15137;
  localparam logic signed [15:0] K_NA   = -16'sd21407;
  localparam logic signed [15:0] K_NB   = -16'sd8867;

  // coefficient row served by a given table slot
  function automatic logic [IDXW-1:0] slot_row(input logic [IDXW-1:0] s);
    logic [IDXW-1:0] r;
    case (s)
      3'd0: r = 3'd7;
      3'd1: r = 3'd5;
      3'd2: r = 3'd1;
      3'd3: r = 3'd3;
      3'd4: r = 3'd0;
      3'd5: r = 3'd2;
      3'd6: r = 3'd4;
      default: r = 3'd6;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/col_acz.sv
module col_acz #(
  parameter int CW = 16,
  parameter int N  = 8
) (
  input  logic [N*CW-1:0] coefs,
  output logic            ac_zero
);
  logic [N-1:1] nz;
  for (genvar k = 1; k < N; k++) begin : g_nz
    assign nz[k] = |coefs[k*CW +: CW];
  end
  assign ac_zero = ~|nz;
endmodule

// File: rtl/col_dequant.sv
module col_dequant #(
  parameter int CW = 16,
  parameter int QW = 16,
  parameter int AW = 32,
  parameter int N  = 8
) (
  input  logic [N*CW-1:0] coefs,
  input  logic [N*QW-1:0] qvals,
  output logic [N*AW-1:0] prods
);
  localparam int PW = CW + QW + 1;
  for (genvar k = 0; k < N; k++) begin : g_mul
    logic signed [PW-1:0] full;
    assign full = $signed(coefs[k*CW +: CW]) * $signed({1'b0, qvals[k*QW +: QW]});
    assign prods[k*AW +: AW] = AW'(full);
  end
endmodule

// File: rtl/col_idct8_core.sv
module col_idct8_core
  import colidct_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [NPT*AW-1:0] x,
  output logic [NPT*AW-1:0] y
);
  function automatic logic signed [AW-1:0] mulk(input logic signed [AW-1:0] a,
                                                input logic signed [15:0] k);
    logic signed [AW+15:0] p;
    p = a * k;
    return AW'(p >>> 16);
  endfunction

  logic signed [AW-1:0] d [NPT];
  for (genvar k = 0; k < NPT; k++) begin : g_unpack
    assign d[k] = x[k*AW +: AW];
  end

  logic signed [AW-1:0] e_sum, e_df, p26, q26, r26, m26;
  logic signed [AW-1:0] ev0, ev1, ev2, ev3;
  logic signed [AW-1:0] o17, o35, z17, z53, odif, osum, rod, tmix, u5, u7;
  logic signed [AW-1:0] w4, w5, w6;
  logic signed [AW-1:0] y0v, y1v, y2v, y3v, y4v, y5v, y6v, y7v;

  // even half
  assign e_sum = d[0] + d[4];
  assign e_df  = (d[0] <<< 1) - e_sum;
  assign p26   = d[6] + d[2];
  assign q26   = (d[2] <<< 1) - p26;
  assign r26   = mulk(q26, K_R2M1) + q26;
  assign ev0   = e_sum + p26;
  assign m26   = r26 - p26;
  assign ev3   = ev0 - (p26 <<< 1);
  assign ev1   = e_df + m26;
  assign ev2   = ev1 - (m26 <<< 1);

  // odd half
  assign o17  = d[1] + d[7];
  assign o35  = d[3] + d[5];
  assign z17  = o17 - (d[7] <<< 1);
  assign z53  = (d[5] <<< 1) - o35;
  assign odif = o17 - o35;
  assign osum = odif + (o35 <<< 1);
  assign tmix = mulk(z53 + z17, K_C2);
  assign rod  = mulk(odif, K_R2M1) + odif;
  assign u5   = mulk(z53, K_NA) + tmix;
  assign u7   = mulk(z17, K_NB) + tmix;
  assign w6   = (u5 <<< 3) - osum;
  assign w5   = rod - w6;
  assign w4   = (u7 <<< 3) - w5;

  // recombination
  assign y0v = ev0 + osum;
  assign y7v = y0v - (osum <<< 1);
  assign y1v = ev1 + w6;
  assign y6v = y1v - (w6 <<< 1);
  assign y2v = ev2 + w5;
  assign y5v = y2v - (w5 <<< 1);
  assign y3v = ev3 + w4;
  assign y4v = y3v - (w4 <<< 1);

  assign y = {y7v, y6v, y5v, y4v, y3v, y2v, y1v, y0v};
endmodule

// File: rtl/col_idct_pass1.sv
module col_idct_pass1
  import colidct_pkg::*;
#(
  parameter int CW = 16,
  parameter int QW = 16,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 done,
  input  logic                 col_valid,
  output logic                 col_ready,
  input  logic [NPT*CW-1:0]    col_coef,
  output logic                 qt_rd_en,
  output logic [2*IDXW-1:0]    qt_addr,
  input  logic [QW-1:0]        qt_rdata,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [2*IDXW-1:0]    wr_addr,
  output logic [AW-1:0]        wr_data
);
  localparam int QAW = 2 * IDXW;

  seq_st_e             st;
  logic [IDXW-1:0]     cidx, islot, ek, cap_slot;
  logic [QAW-1:0]      qptr;
  logic                acz_in, acz_q, cap_v, done_q;
  logic [NPT*CW-1:0]   coef_q;
  logic [NPT*QW-1:0]   qv_flat;
  logic [NPT*AW-1:0]   dq_flat, core_flat, res_q;

  col_acz #(.CW(CW), .N(NPT)) u_acz (
    .coefs   (col_coef),
    .ac_zero (acz_in)
  );

  col_dequant #(.CW(CW), .QW(QW), .AW(AW), .N(NPT)) u_dq (
    .coefs (coef_q),
    .qvals (qv_flat),
    .prods (dq_flat)
  );

  col_idct8_core #(.AW(AW)) u_core (
    .x (dq_flat),
    .y (core_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cidx     <= '0;
      qptr     <= '0;
      islot    <= '0;
      ek       <= '0;
      acz_q    <= 1'b0;
      coef_q   <= '0;
      qv_flat  <= '0;
      res_q    <= '0;
      cap_v    <= 1'b0;
      cap_slot <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      cap_v    <= (st == ST_FETCH);
      cap_slot <= islot;
      if (cap_v) qv_flat[int'(slot_row(cap_slot))*QW +: QW] <= qt_rdata;
      unique case (st)
        ST_IDLE: if (start) begin
          st   <= ST_TAKE;
          cidx <= '0;
          qptr <= '0;
        end
        ST_TAKE: if (col_valid) begin
          coef_q <= col_coef;
          acz_q  <= acz_in;
          islot  <= acz_in ? DC_SLOT : '0;
          st     <= ST_FETCH;
        end
        ST_FETCH: begin
          if (acz_q || islot == LAST_IDX) st <= ST_DRAIN;
          else islot <= islot + 1'b1;
        end
        ST_DRAIN: st <= ST_CALC;
        ST_CALC: begin
          res_q <= acz_q ? {NPT{dq_flat[AW-1:0]}} : core_flat;
          ek    <= '0;
          st    <= ST_EMIT;
        end
        ST_EMIT: if (wr_ready) begin
          if (ek == LAST_IDX) begin
            qptr <= qptr + QAW'(NPT);
            cidx <= cidx + 1'b1;
            if (cidx == LAST_IDX) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= ST_TAKE;
            end
          end else begin
            ek <= ek + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign col_ready = (st == ST_TAKE);
  assign qt_rd_en  = (st == ST_FETCH);
  assign qt_addr   = qptr + QAW'(islot);
  assign wr_valid  = (st == ST_EMIT);
  assign wr_addr   = {ek, cidx};
  assign wr_data   = res_q[int'(ek)*AW +: AW];
  assign done      = done_q;
endmodule

// File: rtl/col_idct_pass1_chk.sv
module col_idct_pass1_chk #(
  parameter int QAW  = 6,
  parameter int AW   = 32,
  parameter int IDXW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           col_valid,
  input logic           col_ready,
  input logic           qt_rd_en,
  input logic [QAW-1:0] qt_addr,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [QAW-1:0] wr_addr,
  input logic [AW-1:0]  wr_data
);
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_ready |=> !col_ready);

  // R4
  qt_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qt_rd_en && $past(qt_rd_en) |-> qt_addr == $past(qt_addr) + 1'b1);

  // R6
  qt_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qt_rd_en) |-> (qt_addr[IDXW-1:0] == '0) || (qt_addr[IDXW-1:0] == IDXW'(4)));

  // R8
  stage_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !qt_rd_en && !col_ready && !done);
endmodule

bind col_idct_pass1 col_idct_pass1_chk #(.QAW(QAW), .AW(AW), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .col_valid (col_valid),
  .col_ready (col_ready),
  .qt_rd_en  (qt_rd_en),
  .qt_addr   (qt_addr),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/col_idct_pass1_tb_top.sv
module col_idct_pass1_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         done;
  logic         col_valid = 1'b0;
  logic         col_ready;
  logic [127:0] col_coef = '0;
  logic         qt_rd_en;
  logic [5:0]   qt_addr;
  logic [15:0]  qt_rdata = '0;
  logic         wr_valid;
  logic         wr_ready = 1'b0;
  logic [5:0]   wr_addr;
  logic [31:0]  wr_data;

  col_idct_pass1 dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .col_valid(col_valid), .col_ready(col_ready), .col_coef(col_coef),
    .qt_rd_en(qt_rd_en), .qt_addr(qt_addr), .qt_rdata(qt_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  localparam int ORD [8] = '{7, 5, 1, 3, 0, 2, 4, 6};

  logic [15:0]        qmem [64];
  logic signed [15:0] cf   [64];   // index 8*c + row
  bit                 byp  [8];
  logic [31:0]        exp_d [64];  // by buffer address

  // monitor logs
  logic [5:0]  wl_addr [128];
  logic [31:0] wl_data [128];
  int          wl_n = 0;
  logic [5:0]  rl_addr [128];
  int          rl_n = 0;
  int          done_n = 0;
  int          stall_p = 0;
  bit          hold_pend = 1'b0;
  logic [5:0]  hold_addr;
  logic [31:0] hold_data;

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  // table model: one-cycle read latency
  always @(posedge clk) if (qt_rd_en) qt_rdata <= qmem[qt_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check(wr_valid && wr_addr == hold_addr && wr_data == hold_data, "R9 held write",
              {26'd0, wr_addr, wr_data}, {26'd0, hold_addr, hold_data});
        hold_pend = 1'b0;
      end
      wr_ready = ($urandom_range(99) >= stall_p);
      if (wr_valid && wr_ready) begin
        if (wl_n < 128) begin wl_addr[wl_n] = wr_addr; wl_data[wl_n] = wr_data; end
        wl_n++;
      end else if (wr_valid) begin
        hold_pend = 1'b1; hold_addr = wr_addr; hold_data = wr_data;
      end
      if (qt_rd_en) begin
        if (rl_n < 128) rl_addr[rl_n] = qt_addr;
        rl_n++;
      end
      if (done) done_n++;
    end
  end

  function automatic logic signed [31:0] mh(input logic signed [31:0] a, input int k);
    longint p;
    p = longint'(a) * longint'(k);
    return 32'(p >>> 16);
  endfunction

  function automatic logic signed [31:0] prod(input int c, input int row, input int slot);
    longint p;
    p = longint'(cf[8*c+row]) * longint'({16'd0, qmem[8*c+slot]});
    return 32'(p);
  endfunction

  function automatic void ref_col(input int c);
    logic signed [31:0] d [8];
    logic signed [31:0] y [8];
    logic signed [31:0] e0, e1, e2, e3, mm, s, pp, a, b, t, w4, w5, w6, g, h;
    for (int s2 = 0; s2 < 8; s2++) d[ORD[s2]] = prod(c, ORD[s2], s2);
    if (byp[c]) begin
      for (int k = 0; k < 8; k++) y[k] = d[0];          // R5 R3
    end else begin                                       // R7 R3
      g  = d[2] - d[6];
      mm = mh(g, 27146) + g - (d[2] + d[6]);
      e0 = (d[0] + d[4]) + (d[2] + d[6]);
      e3 = (d[0] + d[4]) - (d[2] + d[6]);
      e1 = (d[0] - d[4]) + mm;
      e2 = (d[0] - d[4]) - mm;
      s  = (d[1] + d[7]) + (d[3] + d[5]);
      h  = (d[1] + d[7]) - (d[3] + d[5]);
      pp = mh(h, 27146) + h;
      a  = d[5] - d[3];
      b  = d[1] - d[7];
      t  = mh(a + b, 15137);
      w6 = 32'((mh(a, -21407) + t) * 8) - s;
      w5 = pp - w6;
      w4 = 32'((mh(b, -8867) + t) * 8) - w5;
      y[0] = e0 + s;  y[7] = e0 - s;
      y[1] = e1 + w6; y[6] = e1 - w6;
      y[2] = e2 + w5; y[5] = e2 - w5;
      y[3] = e3 + w4; y[4] = e3 - w4;
    end
    for (int k = 0; k < 8; k++) exp_d[8*k+c] = y[k];   // R8 address 8k+c
  endfunction

  task automatic build_block(input int blk);
    for (int i = 0; i < 64; i++) qmem[i] = 16'($urandom_range(65535));
    for (int c = 0; c < 8; c++) begin
      byp[c] = ($urandom_range(2) == 0);
      for (int r = 0; r < 8; r++)
        cf[8*c+r] = (blk % 2 == 1) ? 16'($signed($urandom_range(200)) - 100) : 16'($urandom);
    end
    if (blk == 0) begin
      byp = '{1, 1, 0, 1, 0, 0, 0, 1};
      for (int r = 0; r < 8; r++) begin
        cf[8*4+r] = r[0] ? 16'sh7fff : 16'sh8000;   // extremes with full multipliers
        qmem[8*4+r] = 16'hffff;
        cf[8*5+r] = (r == 7) ? 16'sd1 : 16'sd0;     // only the last AC term set
        cf[8*6+r] = (r == 1) ? 16'sd1 : 16'sd0;     // only the first AC term set
      end
      cf[8*0] = 16'sd100;
      cf[8*1] = 16'sh8000;
      cf[8*3] = 16'sd0;
      cf[8*7] = 16'sh7fff;
    end
    for (int c = 0; c < 8; c++)
      if (byp[c]) for (int r = 1; r < 8; r++) cf[8*c+r] = 16'sd0;
    for (int c = 0; c < 8; c++) ref_col(c);
  endtask

  task automatic send_col(input int c);
    for (int r = 0; r < 8; r++) col_coef[16*r +: 16] = cf[8*c+r];
    col_valid = 1'b1;
    while (!col_ready) @(negedge clk);
    @(negedge clk);
    col_valid = 1'b0;
  endtask

  task automatic verify_block(input int blk);
    int ri;
    check(wl_n == 64, "R8 write count", 64'(wl_n), 64);
    for (int i = 0; i < 64 && i < wl_n; i++) begin
      logic [5:0] ea;
      int c;
      c  = i / 8;
      ea = 6'(8 * (i % 8) + c);
      check(wl_addr[i] == ea, "R8 write address order", 64'(wl_addr[i]), 64'(ea));
      check(wl_data[i] == exp_d[ea], byp[c] ? "R5 R3 bypass value" : "R7 R3 transform value",
            64'(wl_data[i]), 64'(exp_d[ea]));
    end
    ri = 0;
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 8; s++) begin
        if (byp[c] && s != 4) continue;
        if (ri < rl_n && ri < 128)
          check(rl_addr[ri] == 6'(8*c+s), byp[c] ? "R5 R6 DC-only read" : "R4 R6 read sequence",
                64'(rl_addr[ri]), 64'(8*c+s));
        ri++;
      end
    end
    check(rl_n == ri, "R5 R4 read count", 64'(rl_n), 64'(ri));
    check(done_n == 1, $sformatf("R10 done count blk %0d", blk), 64'(done_n), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    int guard;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    check(!col_ready, "R1 col_ready in reset", 64'(col_ready), 0);
    check(!wr_valid,  "R1 wr_valid in reset",  64'(wr_valid), 0);
    check(!qt_rd_en,  "R1 qt_rd_en in reset",  64'(qt_rd_en), 0);
    check(!done,      "R1 done in reset",      64'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!col_ready, "R2 idle without start", 64'(col_ready), 0);
    start = 1'b1;
    for (int blk = 0; blk < NBLK; blk++) begin
      build_block(blk);
      wl_n = 0; rl_n = 0; done_n = 0;
      stall_p = blk * 15;
      @(negedge clk);
      start = 1'b0;
      check(col_ready, "R2 R10 col_ready after start", 64'(col_ready), 1);
      for (int c = 0; c < 8; c++) begin
        send_col(c);
        if (blk == 2 && c == 3) begin
          start = 1'b1;                       // R2: ignored while busy
          @(negedge clk);
          start = 1'b0;
        end
        repeat ($urandom_range(2)) @(negedge clk);
      end
      guard = 0;
      while (!done && guard < 5000) begin @(negedge clk); guard++; end
      check(done, "R10 done reached", 64'(done), 1);
      if (blk < NBLK - 1) start = 1'b1;       // R10: start in the done cycle
      #1;
      verify_block(blk);
    end
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule